// File: doc/BRIEF.md
# Per-Circuit Buffered-Cell Counter with Credit Return

This block sits on the receive side of one switch port. It snoops two shared broadcast buses. One announces every cell written into the common cell memory, and the other announces every cell read out of it. Each bus carries a circuit number and a strobe. A small ownership bitmap marks the circuits whose cells enter through this port, and events for any other circuit are ignored. For each owned circuit the block keeps the number of cells currently held in the common memory.

Two results come from that count. When a programmed number of cells of a circuit have left memory, the block queues a credit notice, made of the circuit number and the number of freed cells. The notice goes to the transmit side of the same port, which sends the credit upstream. The block also raises a per-circuit over-limit flag while a circuit holds more cells than its allowance. Admission logic uses that flag to drop further cells of the circuit. A departure for a circuit with nothing buffered changes no count and sets a sticky error flag.

Top module: `vct_credit_tracker`

## Requirements
- R1: After reset every count and freed tally is zero, the ownership bitmap is clear, `crd_valid`, every `over_limit` bit and `count_err` are low.
- R2: An arrival strobe for an owned circuit adds one to its count. Bus events whose circuit bit in the ownership bitmap is clear change nothing and raise no error. Writing `own_we` with `own_set` sets or clears the bit of `own_cid` from the next cycle on.
- R3: A departure for an owned circuit with a nonzero count subtracts one and adds one to that circuit's freed tally. When the tally reaches the effective batch size, a notice (`crd_vc` = circuit, `crd_amt` = tally) is queued and the tally returns to zero. The notice is visible one cycle after the departure.
- R4: An arrival and a departure for the same owned circuit in the same cycle leave its count unchanged. The departure still adds to the freed tally and never counts as an error.
- R5: A lone departure for an owned circuit whose count is zero changes nothing and sets `count_err`, which stays set until reset.
- R6: `over_limit[v]` is high exactly while the count of circuit v exceeds LIMIT (default 100). Counts saturate at 255, and arrivals beyond that are not counted.
- R7: The effective batch size is `batch_cfg`, with 0 taken as 1 and values above MAX_BATCH (16) taken as 16.
- R8: Notices wait in a 4-entry first-in first-out queue and leave in order, one per cycle in which `crd_valid` and `crd_ready` are both high. While the queue is full, freed cells keep accumulating in the tally, and the next departure of that circuit after space opens queues the whole accumulated amount.
- R9: While `crd_valid` is high and `crd_ready` is low, `crd_valid`, `crd_vc` and `crd_amt` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| own_we | input | 1 | Ownership bitmap write strobe |
| own_cid | input | 6 | Circuit whose ownership bit is written |
| own_set | input | 1 | Value written into the ownership bit |
| batch_cfg | input | 5 | Freed cells per credit notice (clamped to 1..16) |
| arr_valid | input | 1 | Arrival bus strobe |
| arr_cid | input | 6 | Arrival bus circuit number |
| dep_valid | input | 1 | Departure bus strobe |
| dep_cid | input | 6 | Departure bus circuit number |
| crd_valid | output | 1 | A credit notice is offered |
| crd_ready | input | 1 | Transmit side accepts the notice |
| crd_vc | output | 6 | Circuit of the offered notice |
| crd_amt | output | 8 | Freed cells covered by the notice |
| over_limit | output | 64 | Per-circuit over-allowance flags |
| count_err | output | 1 | Sticky departure-at-zero error |

## Verification
The embedded properties check invariants that hold on every cycle. A count never moves by more than one step per cycle. An over-limit flag only rises from a count sitting exactly at the limit. The error flag never falls outside reset, the queue is never pushed while full, and an offered notice stays frozen while back-pressured. Other behaviour can only be shown by the bench's scenarios: which events the ownership bitmap filters out, when a batch actually completes, the clamping of batch sizes, and the accumulated amount after a full queue. The same holds for the exact boundary at 100 and 255 cells and for the same-cycle arrival and departure case.

// File: rtl/vct_pkg.sv
package vct_pkg;

   typedef enum logic [1:0] {
      EV_NONE = 2'd0,
      EV_INC  = 2'd1,
      EV_DEC  = 2'd2,
      EV_HOLD = 2'd3
   } vct_event_e;

   function automatic int vct_clamp_batch(input int raw, input int max_b);
      if (raw < 1)
         return 1;
      else if (raw > max_b)
         return max_b;
      else
         return raw;
   endfunction

endpackage

// File: rtl/vct_own_table.sv
module vct_own_table #(
   parameter int CID_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CID_W-1:0] wr_cid,
   input  logic             wr_val,
   input  logic [CID_W-1:0] rd_a_cid,
   input  logic [CID_W-1:0] rd_b_cid,
   output logic             rd_a_own,
   output logic             rd_b_own
);
   localparam int N = 1 << CID_W;

   logic [N-1:0] own_bits;

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)
            own_bits[i] <= 1'b0;
         else if (wr_en && (wr_cid == CID_W'(i)))
            own_bits[i] <= wr_val;
      end
   end

   assign rd_a_own = own_bits[rd_a_cid];
   assign rd_b_own = own_bits[rd_b_cid];

endmodule

// File: rtl/vct_vc_slice.sv
module vct_vc_slice
   import vct_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int LIMIT = 100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit_arr,
   input  logic             hit_dep,
   input  logic [CNT_W-1:0] batch,
   input  logic             q_full,
   output logic             over,
   output logic             emit,
   output logic             underflow,
   output logic [CNT_W-1:0] freed_inc
);
   localparam logic [CNT_W-1:0] CMAX = '1;
   localparam logic [CNT_W-1:0] LIM  = CNT_W'(LIMIT);

   vct_event_e       ev;
   logic [CNT_W-1:0] cnt, cnt_nxt;
   logic [CNT_W-1:0] freed, freed_nxt;
   logic             dep_ok;

   always_comb begin
      unique case ({hit_arr, hit_dep})
         2'b11:   ev = EV_HOLD;
         2'b10:   ev = EV_INC;
         2'b01:   ev = EV_DEC;
         default: ev = EV_NONE;
      endcase
   end

   always_comb begin
      cnt_nxt   = cnt;
      underflow = 1'b0;
      dep_ok    = 1'b0;
      case (ev)
         EV_INC:  if (cnt != CMAX) cnt_nxt = cnt + 1'b1;
         EV_DEC: begin
            if (cnt == '0)
               underflow = 1'b1;
            else begin
               cnt_nxt = cnt - 1'b1;
               dep_ok  = 1'b1;
            end
         end
         EV_HOLD: dep_ok = 1'b1;
         default: ;
      endcase
   end

   always_comb begin
      freed_inc = freed;
      if (dep_ok && (freed != CMAX))
         freed_inc = freed + 1'b1;
      emit      = dep_ok && (freed_inc >= batch) && !q_full;
      freed_nxt = emit ? '0 : freed_inc;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         freed <= '0;
      end else begin
         cnt   <= cnt_nxt;
         freed <= freed_nxt;
      end
   end

   assign over = (cnt > LIM);

   // R2
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != $past(cnt)) |-> ((cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1)));

   // R6
   over_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(over) |-> ($past(cnt) == LIM));

endmodule

// File: rtl/vct_notice_fifo.sv
module vct_notice_fifo #(
   parameter int W     = 14,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic         full,
   output logic         valid,
   output logic [W-1:0] head
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int OW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wptr, rptr;
   logic [OW-1:0] occ;
   logic          do_pop;

   assign full   = (occ == OW'(DEPTH));
   assign valid  = (occ != '0);
   assign head   = mem[rptr];
   assign do_pop = pop && valid;

   function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         occ  <= '0;
      end else begin
         if (push) begin
            mem[wptr] <= push_data;
            wptr      <= nxt(wptr);
         end
         if (do_pop)
            rptr <= nxt(rptr);
         if (push && !do_pop)
            occ <= occ + 1'b1;
         else if (do_pop && !push)
            occ <= occ - 1'b1;
      end
   end

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);

   // R8
   occ_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= OW'(DEPTH));

endmodule

// File: rtl/vct_credit_tracker.sv
module vct_credit_tracker
   import vct_pkg::*;
#(
   parameter int CID_W      = 6,
   parameter int CNT_W      = 8,
   parameter int LIMIT      = 100,
   parameter int MAX_BATCH  = 16,
   parameter int FIFO_DEPTH = 4,
   localparam int NUM_VC    = 1 << CID_W,
   localparam int BAT_W     = $clog2(MAX_BATCH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              own_we,
   input  logic [CID_W-1:0]  own_cid,
   input  logic              own_set,
   input  logic [BAT_W-1:0]  batch_cfg,
   input  logic              arr_valid,
   input  logic [CID_W-1:0]  arr_cid,
   input  logic              dep_valid,
   input  logic [CID_W-1:0]  dep_cid,
   output logic              crd_valid,
   input  logic              crd_ready,
   output logic [CID_W-1:0]  crd_vc,
   output logic [CNT_W-1:0]  crd_amt,
   output logic [NUM_VC-1:0] over_limit,
   output logic              count_err
);
   localparam int NW = CID_W + CNT_W;

   if (LIMIT < 1 || LIMIT >= (1 << CNT_W) - 1) begin : g_bad_limit
      initial $fatal(1, "LIMIT must fit below the counter ceiling");
   end
   if (MAX_BATCH < 1 || MAX_BATCH >= (1 << CNT_W)) begin : g_bad_batch
      initial $fatal(1, "MAX_BATCH out of range for CNT_W");
   end
   if (FIFO_DEPTH < 1) begin : g_bad_depth
      initial $fatal(1, "FIFO_DEPTH must be at least one");
   end

   logic              arr_own, dep_own;
   logic [NUM_VC-1:0] emit_v, under_v;
   logic [CNT_W-1:0]  freed_v [NUM_VC];
   logic [CNT_W-1:0]  batch_eff;
   logic              q_full, q_push;
   logic [NW-1:0]     q_in, q_head;

   assign batch_eff = CNT_W'(vct_clamp_batch(int'(batch_cfg), MAX_BATCH));

   vct_own_table #(.CID_W(CID_W)) u_own (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (own_we),
      .wr_cid   (own_cid),
      .wr_val   (own_set),
      .rd_a_cid (arr_cid),
      .rd_b_cid (dep_cid),
      .rd_a_own (arr_own),
      .rd_b_own (dep_own)
   );

   for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
      logic ha, hd;
      assign ha = arr_valid && arr_own && (arr_cid == CID_W'(v));
      assign hd = dep_valid && dep_own && (dep_cid == CID_W'(v));

      vct_vc_slice #(.CNT_W(CNT_W), .LIMIT(LIMIT)) u_slice (
         .clk       (clk),
         .rst_n     (rst_n),
         .hit_arr   (ha),
         .hit_dep   (hd),
         .batch     (batch_eff),
         .q_full    (q_full),
         .over      (over_limit[v]),
         .emit      (emit_v[v]),
         .underflow (under_v[v]),
         .freed_inc (freed_v[v])
      );
   end

   assign q_push = |emit_v;
   assign q_in   = {dep_cid, freed_v[dep_cid]};

   vct_notice_fifo #(.W(NW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (q_push),
      .push_data (q_in),
      .pop       (crd_ready),
      .full      (q_full),
      .valid     (crd_valid),
      .head      (q_head)
   );

   assign crd_vc  = q_head[NW-1:CNT_W];
   assign crd_amt = q_head[CNT_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n)
         count_err <= 1'b0;
      else if (|under_v)
         count_err <= 1'b1;
   end

   // R5
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(count_err) |-> count_err);

   // R9
   crd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (crd_valid && !crd_ready) |=> (crd_valid && $stable(crd_vc) && $stable(crd_amt)));

   // R3
   one_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(emit_v));

   // R7
   amt_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      crd_valid |-> (crd_amt != '0));

endmodule

// File: tb/vct_credit_tracker_bench.sv
module vct_credit_tracker_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        own_we, own_set;
   logic [5:0]  own_cid;
   logic [4:0]  batch_cfg;
   logic        arr_valid, dep_valid;
   logic [5:0]  arr_cid, dep_cid;
   logic        crd_valid, crd_ready;
   logic [5:0]  crd_vc;
   logic [7:0]  crd_amt;
   logic [63:0] over_limit;
   logic        count_err;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   vct_credit_tracker u_vct_credit_tracker (
      .clk(clk), .rst_n(rst_n), .own_we(own_we), .own_cid(own_cid),
      .own_set(own_set), .batch_cfg(batch_cfg), .arr_valid(arr_valid),
      .arr_cid(arr_cid), .dep_valid(dep_valid), .dep_cid(dep_cid),
      .crd_valid(crd_valid), .crd_ready(crd_ready), .crd_vc(crd_vc),
      .crd_amt(crd_amt), .over_limit(over_limit), .count_err(count_err)
   );

   always #2 clk = ~clk;

   // vector: {arr_v, arr_cid[5:0], dep_v, dep_cid[5:0], exp_crd_valid, exp_err}
   localparam int NV = 10;
   localparam logic [15:0] VEC [NV] = '{
      {1'b1, 6'd1, 1'b0, 6'd0, 1'b0, 1'b0},  // R2 arrival on owned 1
      {1'b1, 6'd1, 1'b0, 6'd0, 1'b0, 1'b0},
      {1'b1, 6'd1, 1'b0, 6'd0, 1'b0, 1'b0},
      {1'b1, 6'd7, 1'b0, 6'd0, 1'b0, 1'b0},  // R2 not owned
      {1'b0, 6'd0, 1'b1, 6'd7, 1'b0, 1'b0},  // R2 not owned, no error
      {1'b0, 6'd0, 1'b1, 6'd1, 1'b0, 1'b0},  // R3 freed 1
      {1'b0, 6'd0, 1'b1, 6'd1, 1'b0, 1'b0},  // R3 freed 2
      {1'b0, 6'd0, 1'b1, 6'd1, 1'b1, 1'b0},  // R3 batch of 3 done
      {1'b0, 6'd0, 1'b1, 6'd2, 1'b1, 1'b1},  // R5 departure at zero
      {1'b1, 6'd2, 1'b1, 6'd2, 1'b1, 1'b1}   // R4 both on 2
   };

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic ev(input bit av, input int ac, input bit dv, input int dc);
      arr_valid = av; arr_cid = 6'(ac);
      dep_valid = dv; dep_cid = 6'(dc);
      @(negedge clk);
      arr_valid = 1'b0; dep_valid = 1'b0;
   endtask

   task automatic own(input int c);
      own_we = 1'b1; own_cid = 6'(c); own_set = 1'b1;
      @(negedge clk);
      own_we = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic drain(input int vc, input int amt, input string tag);
      chk(crd_valid == 1'b1, tag, int'(crd_valid), 1);
      chk(crd_vc == 6'(vc), tag, int'(crd_vc), vc);
      chk(crd_amt == 8'(amt), tag, int'(crd_amt), amt);
      crd_ready = 1'b1;
      @(negedge clk);
      crd_ready = 1'b0;
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL R1 watchdog actual=0 expected=1");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; own_we = 1'b0; own_set = 1'b0; own_cid = '0;
      batch_cfg = 5'd3; arr_valid = 1'b0; dep_valid = 1'b0;
      arr_cid = '0; dep_cid = '0; crd_ready = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(crd_valid == 1'b0, "R1 crd_valid", int'(crd_valid), 0);
      chk(over_limit == '0, "R1 over_limit", int'(over_limit != '0), 0);
      chk(count_err == 1'b0, "R1 count_err", int'(count_err), 0);
      rst_n = 1'b1;
      own(1); own(2); own(5);

      for (int i = 0; i < NV; i++) begin
         ev(VEC[i][15], int'(VEC[i][14:9]), VEC[i][8], int'(VEC[i][7:2]));
         chk(crd_valid == VEC[i][1], $sformatf("R3 vec%0d valid", i), int'(crd_valid), int'(VEC[i][1]));
         chk(count_err == VEC[i][0], $sformatf("R5 vec%0d err", i), int'(count_err), int'(VEC[i][0]));
      end
      drain(1, 3, "R3 notice");
      chk(crd_valid == 1'b0, "R3 queue empty", int'(crd_valid), 0);

      // R4: same-cycle both keeps zero, so a later lone departure errors
      do_reset(); batch_cfg = 5'd16; own(3);
      ev(1, 3, 1, 3);
      chk(count_err == 1'b0, "R4 both no error", int'(count_err), 0);
      ev(0, 0, 1, 3);
      chk(count_err == 1'b1, "R4 count stayed zero", int'(count_err), 1);
      do_reset(); own(3);
      ev(1, 3, 0, 0); ev(1, 3, 1, 3); ev(0, 0, 1, 3);
      chk(count_err == 1'b0, "R4 count stayed one", int'(count_err), 0);
      ev(0, 0, 1, 3);
      chk(count_err == 1'b1, "R5 now at zero", int'(count_err), 1);
      ev(1, 3, 0, 0);
      chk(count_err == 1'b1, "R5 sticky", int'(count_err), 1);

      // R6 limit boundary and saturation
      do_reset(); own(4); crd_ready = 1'b1;
      for (int i = 0; i < 100; i++) ev(1, 4, 0, 0);
      chk(over_limit[4] == 1'b0, "R6 at limit", int'(over_limit[4]), 0);
      ev(1, 4, 0, 0);
      chk(over_limit[4] == 1'b1, "R6 above limit", int'(over_limit[4]), 1);
      chk(over_limit[3] == 1'b0, "R6 other vc", int'(over_limit[3]), 0);
      ev(0, 0, 1, 4);
      chk(over_limit[4] == 1'b0, "R6 back to limit", int'(over_limit[4]), 0);
      for (int i = 0; i < 160; i++) ev(1, 4, 0, 0);
      for (int i = 0; i < 255; i++) ev(0, 0, 1, 4);
      chk(count_err == 1'b0, "R6 saturated count drains", int'(count_err), 0);
      chk(over_limit[4] == 1'b0, "R6 flag clear", int'(over_limit[4]), 0);
      ev(0, 0, 1, 4);
      chk(count_err == 1'b1, "R6 saturation at 255", int'(count_err), 1);
      crd_ready = 1'b0;

      // R7 clamping
      do_reset(); own(6); batch_cfg = 5'd0;
      ev(1, 6, 0, 0); ev(1, 6, 0, 0);
      ev(0, 0, 1, 6);
      drain(6, 1, "R7 zero as one");
      batch_cfg = 5'd20;
      for (int i = 0; i < 20; i++) ev(1, 6, 0, 0);
      for (int i = 0; i < 15; i++) ev(0, 0, 1, 6);
      chk(crd_valid == 1'b0, "R7 fifteen not enough", int'(crd_valid), 0);
      ev(0, 0, 1, 6);
      drain(6, 16, "R7 above max as sixteen");

      // R8 full queue accumulation, R9 hold
      do_reset(); batch_cfg = 5'd1;
      for (int c = 8; c <= 12; c++) begin
         own(c);
         for (int k = 0; k < 3; k++) ev(1, c, 0, 0);
      end
      for (int c = 8; c <= 11; c++) ev(0, 0, 1, c);
      ev(0, 0, 1, 12); ev(0, 0, 1, 12);
      repeat (3) @(negedge clk);
      chk(crd_vc == 6'd8, "R9 held vc", int'(crd_vc), 8);
      chk(crd_amt == 8'd1, "R9 held amt", int'(crd_amt), 1);
      drain(8, 1, "R8 order 0");
      ev(0, 0, 1, 12);
      drain(9, 1, "R8 order 1");
      drain(10, 1, "R8 order 2");
      drain(11, 1, "R8 order 3");
      drain(12, 3, "R8 accumulated");
      chk(crd_valid == 1'b0, "R8 empty", int'(crd_valid), 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule